// File: doc/BRIEF.md
# Soft Mute Attenuation Ramp

This block computes an attenuation value, in whole decibels, for a downstream gain stage. When soft mute is requested, the attenuation climbs by one decibel per tick toward a fixed soft-mute depth. When the request is withdrawn, it falls back one decibel per tick toward zero. Because the gain never jumps, the audio does not click. Two ramp speeds are available. A prescaler turns the clock into ticks, and the slow prescale is fourteen times the fast one by default.

A soft-mute request comes from either of two sources:
- a configuration bit, active high;
- an external pin, active low, which overrides the bit.

A separate direct-mute bit puts the full mute depth on the output at once. The ramp keeps running underneath it, so on release the output shows the current ramp level. A status bit follows the request itself, not the progress of the ramp.

Top module: `softmute_ramp`

## Requirements
- R1: While `cfg_soft_en` is 1, the ramp level rises by one on each tick until it reaches the soft depth.
- R2: `soft_status` is 1 in the clock cycle after a soft-mute request is present, whatever the ramp level is. A request is `cfg_soft_en` = 1 or `ext_mute_n` = 0.
- R3: The ramp level never exceeds `SOFT_DEPTH` (default 60) and holds there while the request stays.
- R4: The ramp level changes by exactly one, and only on a tick.
  - Ticks come from a clock counter that starts at 0 after reset and returns to 0 on each tick.
  - A tick occurs when the count is at least the period minus one.
  - The period is `FAST_DIV` (default 8) when `cfg_slow` = 0 and `SLOW_DIV` (default 112) when `cfg_slow` = 1.
- R5: With no request, the ramp level falls by one per tick and stops at 0.
- R6: A change of request in mid-ramp reverses the direction from the current level, with no jump.
- R7: While `cfg_direct` is 1, `att_db` equals `DIRECT_DEPTH` (default 100) in the same cycle. When `cfg_direct` clears, `att_db` returns to the ramp level, which kept moving meanwhile.
- R8: `ext_mute_n` = 0 forces soft mute even when `cfg_soft_en` is 0.
- R9: After reset, `att_db` is 0 and `soft_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_soft_en | input | 1 | Soft-mute request bit |
| cfg_slow | input | 1 | Ramp speed select: 0 fast, 1 slow |
| cfg_direct | input | 1 | Direct mute: full depth at once |
| ext_mute_n | input | 1 | External soft-mute request, active low |
| att_db | output | ATT_W (7) | Current attenuation in dB |
| soft_status | output | 1 | Soft-mute requested flag |

## Verification
The assertions assume that every control input, including `ext_mute_n`, is already synchronous to `clk`, because the block has no synchronizer of its own. They also assume each input holds steady between rising edges. The bench changes every input only at the falling edge. It holds random settings for stretches long enough to see both ramp directions, reversals, speed changes in mid-period and overlaps of direct mute with the ramp.

// File: rtl/smr_pkg.sv
package smr_pkg;
   typedef enum logic {
      SLOPE_FAST = 1'b0,
      SLOPE_SLOW = 1'b1
   } slope_e;
endpackage

// File: rtl/smr_tick.sv
module smr_tick
   import smr_pkg::*;
#(
   parameter int FAST_DIV = 8,
   parameter int SLOW_DIV = 112
) (
   input  logic   clk,
   input  logic   rst_n,
   input  slope_e slope,
   output logic   tick
);
   localparam int CNT_W = $clog2(SLOW_DIV + 1);

   generate
      if (FAST_DIV < 2) begin : g_bad_fast
         $error("FAST_DIV must be at least 2");
      end
      if (SLOW_DIV <= FAST_DIV) begin : g_bad_ratio
         $error("SLOW_DIV must exceed FAST_DIV");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_cnt;

   always_comb begin
      if (slope == SLOPE_SLOW) last_cnt = CNT_W'(SLOW_DIV - 1);
      else                     last_cnt = CNT_W'(FAST_DIV - 1);
   end

   assign tick = (cnt_q >= last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + CNT_W'(1);
   end

   // R4: two ticks are never adjacent, since every period is at least 2
   p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/smr_ramp.sv
module smr_ramp #(
   parameter int ATT_W = 7,
   parameter int DEPTH = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             req,
   output logic [ATT_W-1:0] lvl
);
   localparam logic [ATT_W-1:0] TOP = ATT_W'(DEPTH);

   generate
      if (DEPTH >= (1 << ATT_W) || DEPTH < 1) begin : g_bad_depth
         $error("DEPTH does not fit ATT_W");
      end
   endgenerate

   logic [ATT_W-1:0] lvl_q;
   logic             go_up;
   logic             go_down;

   assign go_up   = tick && req  && (lvl_q < TOP);
   assign go_down = tick && !req && (lvl_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lvl_q <= '0;
      else if (go_up)   lvl_q <= lvl_q + ATT_W'(1);
      else if (go_down) lvl_q <= lvl_q - ATT_W'(1);
   end

   assign lvl = lvl_q;

   p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= TOP);
   p_only_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(lvl_q));
   p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lvl_q) |-> (lvl_q == $past(lvl_q) + ATT_W'(1)) || (lvl_q + ATT_W'(1) == $past(lvl_q)));
   p_rise_on_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req) |-> lvl_q >= $past(lvl_q));
   p_fall_on_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req) |-> lvl_q <= $past(lvl_q));
endmodule

// File: rtl/smr_status.sv
module smr_status #(
   parameter bit REG_STATUS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic status
);
   generate
      if (REG_STATUS) begin : g_reg
         logic st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= 1'b0;
            else        st_q <= req;
         end
         assign status = st_q;
      end else begin : g_comb
         assign status = req;
      end
   endgenerate
endmodule

// File: rtl/softmute_ramp.sv
module softmute_ramp
   import smr_pkg::*;
#(
   parameter int ATT_W        = 7,
   parameter int SOFT_DEPTH   = 60,
   parameter int DIRECT_DEPTH = 100,
   parameter int FAST_DIV     = 8,
   parameter int SLOW_DIV     = 112
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_soft_en,
   input  logic             cfg_slow,
   input  logic             cfg_direct,
   input  logic             ext_mute_n,
   output logic [ATT_W-1:0] att_db,
   output logic             soft_status
);
   localparam logic [ATT_W-1:0] FULL = ATT_W'(DIRECT_DEPTH);
   localparam logic [ATT_W-1:0] SOFT = ATT_W'(SOFT_DEPTH);

   generate
      if (DIRECT_DEPTH >= (1 << ATT_W) || DIRECT_DEPTH < SOFT_DEPTH) begin : g_bad_direct
         $error("DIRECT_DEPTH must fit ATT_W and be at least SOFT_DEPTH");
      end
   endgenerate

   logic             req;
   logic             tick;
   logic [ATT_W-1:0] lvl;
   slope_e           slope;

   assign req   = cfg_soft_en || !ext_mute_n;
   assign slope = slope_e'(cfg_slow);

   smr_tick #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .slope(slope), .tick(tick));

   smr_ramp #(.ATT_W(ATT_W), .DEPTH(SOFT_DEPTH)) u_ramp (
      .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .lvl(lvl));

   smr_status #(.REG_STATUS(1'b1)) u_status (
      .clk(clk), .rst_n(rst_n), .req(req), .status(soft_status));

   assign att_db = cfg_direct ? FULL : lvl;

   p_status_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> soft_status == $past(cfg_soft_en || !ext_mute_n));
   p_ext_forces_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ext_mute_n)) |-> soft_status);
   p_direct_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_direct |-> att_db == FULL);
   p_soft_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_direct |-> att_db <= SOFT);
endmodule

// File: tb/softmute_ramp_tb.sv
module softmute_ramp_tb;
   localparam int CLK_PERIOD = 10;
   localparam int FAST   = 8;
   localparam int SLOW   = 112;
   localparam int SOFTD  = 60;
   localparam int DIRD   = 100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_soft_en = 1'b0;
   logic       cfg_slow = 1'b0;
   logic       cfg_direct = 1'b0;
   logic       ext_mute_n = 1'b1;
   logic [6:0] att_db;
   logic       soft_status;

   int n_cmp = 0;
   int n_bad = 0;

   // reference state, built from the requirements
   int m_cnt = 0;
   int m_lvl = 0;
   int m_st  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   softmute_ramp u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_soft_en(cfg_soft_en), .cfg_slow(cfg_slow),
      .cfg_direct(cfg_direct), .ext_mute_n(ext_mute_n),
      .att_db(att_db), .soft_status(soft_status));

   function automatic int period_now();
      return cfg_slow ? SLOW : FAST;
   endfunction

   function automatic int exp_att();
      return cfg_direct ? DIRD : m_lvl;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_lvl = 0; m_st = 0;
      end else begin
         int req;
         bit tk;
         req = (cfg_soft_en || !ext_mute_n) ? 1 : 0;
         tk  = (m_cnt >= period_now() - 1);
         m_cnt = tk ? 0 : m_cnt + 1;
         if (tk && req == 1 && m_lvl < SOFTD) m_lvl = m_lvl + 1;
         else if (tk && req == 0 && m_lvl > 0) m_lvl = m_lvl - 1;
         m_st = req;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock; compare at the falling edge, before inputs change
   task automatic step();
      @(negedge clk);
      chk(cfg_direct ? "R7" : "R4", int'(att_db), exp_att());
      chk("R2", int'(soft_status), m_st);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int lv;
      void'($urandom(32'h5EED_0017));
      // R9: reset state
      run(3);
      chk("R9", int'(att_db), 0);
      chk("R9", int'(soft_status), 0);
      rst_n = 1'b1;
      run(20);

      // R7: direct mute with ramp idle
      cfg_direct = 1'b1;
      #1 chk("R7", int'(att_db), DIRD);
      run(5);
      cfg_direct = 1'b0;
      #1 chk("R7", int'(att_db), 0);

      // R1, R3: fast ramp to the soft depth and hold
      cfg_soft_en = 1'b1;
      step();
      chk("R2", int'(soft_status), 1);
      chk("R2", int'(att_db) < 2 ? 1 : 0, 1);
      run(FAST * SOFTD + 40);
      chk("R3", int'(att_db), SOFTD);
      chk("R1", int'(soft_status), 1);

      // R5: release to zero
      cfg_soft_en = 1'b0;
      run(FAST * SOFTD + 40);
      chk("R5", int'(att_db), 0);

      // R8: external pin forces soft mute
      ext_mute_n = 1'b0;
      run(FAST * 10 + 2);
      chk("R8", int'(soft_status), 1);
      chk("R8", int'(att_db) >= 9 ? 1 : 0, 1);

      // R6: reversal mid ramp
      lv = int'(att_db);
      ext_mute_n = 1'b1;
      run(FAST * 4);
      chk("R6", int'(att_db), lv - 4 < 0 ? 0 : lv - 4);
      run(FAST * 20);
      chk("R5", int'(att_db), 0);

      // R4: slow slope timing and direct mute over a moving ramp
      cfg_slow = 1'b1;
      cfg_soft_en = 1'b1;
      run(SLOW * 5);
      cfg_direct = 1'b1;
      run(SLOW * 3);
      cfg_direct = 1'b0;
      #1 chk("R7", int'(att_db), m_lvl);
      run(SLOW * 2);
      chk("R4", int'(att_db) >= 9 ? 1 : 0, 1);

      // random mix
      for (int k = 0; k < 300; k++) begin
         cfg_soft_en = 1'($urandom_range(0, 1));
         cfg_slow    = ($urandom_range(0, 3) == 0);
         cfg_direct  = ($urandom_range(0, 7) == 0);
         ext_mute_n  = ($urandom_range(0, 5) != 0);
         run(int'($urandom_range(5, 200)));
      end
      finish_run();
   end
endmodule